// File: doc/BRIEF.md
# Timer and Shift-Event Interrupt Controller

This block gathers the interrupt sources of a small peripheral that has two down-counting timers and a byte shift register. Each source reports an event with a one-cycle pulse. The pulse latches a bit in a 7-bit pending register. A 7-bit mask register chooses which pending bits may raise the single level-sensitive interrupt line. Software reaches both registers through a byte-wide port. Neighbouring blocks send one-cycle strobes when software reads a timer low count byte or the shift data. Each strobe retires its matching pending bit.

Pending bits are cleared by writing ones to them. Mask bits are changed through a selector in data bit 7: when bit 7 is 1, the ones in bits 6..0 set mask bits, and when bit 7 is 0, they clear mask bits. A status read returns a summary in bit 7. A mask read always returns bit 7 as 1. The interrupt line comes from a register, so it follows the register state one clock later.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: `irq` is registered. In the cycle after any clock edge, it is 1 exactly when the pending and mask registers shared at least one set bit before that edge.
- R2: A write to the status address (default 0xD) clears each pending bit whose data bit is 1. Pending bits under data zeros keep their value.
- R3: A write to the mask address (default 0xE) with data bit 7 = 1 sets each mask bit whose data bit (6..0) is 1. The other mask bits keep their value.
- R4: A write to the mask address with data bit 7 = 0 clears each mask bit whose data bit (6..0) is 1. The other mask bits keep their value.
- R5: A read at the status address returns the pending bits in bits 6..0. Bit 7 is 1 when any pending bit is also enabled.
- R6: A read at the mask address returns the mask in bits 6..0 and always returns 1 in bit 7.
- R7: The shift-data strobe clears pending bit 2, the timer-2 strobe clears bit 5 and the timer-1 strobe clears bit 6. No strobe touches any other bit.
- R8: A pulse on `set_evt[i]` sets pending bit i. This includes the unassigned bits 0, 1, 3 and 4, which hold and read back like the others.
- R9: If a set pulse and a clear (a write or a strobe) reach the same pending bit in the same cycle, the bit ends up set.
- R10: After reset, the pending and mask registers are zero and `irq` is 0.
- R11: Writes to any other address change neither register, and reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register (combinational) |
| set_evt | input | 7 | One-cycle event pulses, one per pending bit |
| rdclr_shift | input | 1 | Side-effect clear from a shift-data read |
| rdclr_tmr1 | input | 1 | Side-effect clear from a timer-1 low-count read |
| rdclr_tmr2 | input | 1 | Side-effect clear from a timer-2 low-count read |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that every input is a known value at each rising edge. They also assume that events and strobes are sampled as single-cycle levels, with no handshake between them. The set-wins and clear properties look only at the cycle after a stimulus. They therefore hold under any mix of simultaneous sets, writes and strobes. The bench drives all inputs on the falling edge and holds them through the next rising edge. It then mixes directed collisions with random sequences of writes, strobes and sparse events over all three address classes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W  = 8;
  localparam int FLAG_W  = DATA_W - 1;
  localparam int SEL_BIT = DATA_W - 1;
  localparam int BIT_SHIFT = 2;
  localparam int BIT_TMR2  = 5;
  localparam int BIT_TMR1  = 6;
  typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank
  import irqc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_hit,
  input  flag_vec_t wr_mask,
  input  logic      clr_shift,
  input  logic      clr_tmr1,
  input  logic      clr_tmr2,
  input  flag_vec_t set_vec,
  output flag_vec_t flags
);
  flag_vec_t flags_q, flags_nxt, rd_clr, wr_clr;

  always_comb begin
    rd_clr = '0;
    rd_clr[BIT_SHIFT] = clr_shift;
    rd_clr[BIT_TMR1]  = clr_tmr1;
    rd_clr[BIT_TMR2]  = clr_tmr2;
  end

  genvar gi;
  generate
    for (gi = 0; gi < FLAG_W; gi++) begin : g_bit
      assign wr_clr[gi] = wr_hit & wr_mask[gi];
      // set has priority over any clear source
      assign flags_nxt[gi] = set_vec[gi] | (flags_q[gi] & ~wr_clr[gi] & ~rd_clr[gi]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_nxt;
  end

  assign flags = flags_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec))); // R9

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && set_vec == '0) |=> ((flags & $past(wr_mask)) == '0)); // R2

  AST_STROBE_T1: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tmr1 && !set_vec[BIT_TMR1]) |=> !flags[BIT_TMR1]); // R7
endmodule

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output flag_vec_t         enables
);
  flag_vec_t en_q, en_nxt, bits;
  logic      set_sel;

  assign bits    = wdata[FLAG_W-1:0];
  assign set_sel = wdata[SEL_BIT];

  always_comb begin
    en_nxt = en_q;
    if (set_sel) en_nxt = en_q | bits;
    else         en_nxt = en_q & ~bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_hit) en_q <= en_nxt;
  end

  assign enables = en_q;

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && set_sel) |=> ((enables & $past(bits)) == $past(bits))); // R3

  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !set_sel) |=> ((enables & $past(bits)) == '0)); // R4

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(enables)); // R11
endmodule

// File: rtl/irqc_readback.sv
module irqc_readback
  import irqc_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 13,
  parameter int MASK_ADDR = 14
) (
  input  logic [ADDR_W-1:0] addr,
  input  flag_vec_t         flags,
  input  flag_vec_t         enables,
  output logic [DATA_W-1:0] rdata
);
  logic any_live;
  assign any_live = |(flags & enables);

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(STAT_ADDR))      rdata = {any_live, flags};
    else if (addr == ADDR_W'(MASK_ADDR)) rdata = {1'b1, enables};
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 13,
  parameter int MASK_ADDR = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [FLAG_W-1:0] set_evt,
  input  logic              rdclr_shift,
  input  logic              rdclr_tmr1,
  input  logic              rdclr_tmr2,
  output logic              irq
);
  flag_vec_t flags, enables;
  logic      stat_wr, mask_wr, irq_q, irq_nxt;

  assign stat_wr = reg_wr & (reg_addr == ADDR_W'(STAT_ADDR));
  assign mask_wr = reg_wr & (reg_addr == ADDR_W'(MASK_ADDR));

  irqc_flag_bank u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (stat_wr),
    .wr_mask   (reg_wdata[FLAG_W-1:0]),
    .clr_shift (rdclr_shift),
    .clr_tmr1  (rdclr_tmr1),
    .clr_tmr2  (rdclr_tmr2),
    .set_vec   (set_evt),
    .flags     (flags)
  );

  irqc_enable_bank u_enables (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (mask_wr),
    .wdata   (reg_wdata),
    .enables (enables)
  );

  irqc_readback #(
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR),
    .MASK_ADDR (MASK_ADDR)
  ) u_readback (
    .addr    (reg_addr),
    .flags   (flags),
    .enables (enables),
    .rdata   (reg_rdata)
  );

  assign irq_nxt = |(flags & enables);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_nxt;
  end

  assign irq = irq_q;

  AST_IRQ_LAGS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(STAT_ADDR)) |=> (irq == $past(reg_rdata[SEL_BIT]))); // R1

  AST_MASK_RD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(MASK_ADDR)) |-> reg_rdata[SEL_BIT]); // R6

  AST_OTHER_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != ADDR_W'(STAT_ADDR) && reg_addr != ADDR_W'(MASK_ADDR)) |-> (reg_rdata == '0)); // R11
endmodule

// File: tb/tmr_irq_ctrl_tb.sv
module tmr_irq_ctrl_tb;
  localparam logic [3:0] A_STAT = 4'hD;
  localparam logic [3:0] A_MASK = 4'hE;

  logic       clk, rst_n, reg_wr, rdclr_shift, rdclr_tmr1, rdclr_tmr2;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [6:0] set_evt;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [6:0] m_flag, m_en;
  logic       m_irq;

  tmr_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_evt(set_evt),
    .rdclr_shift(rdclr_shift), .rdclr_tmr1(rdclr_tmr1), .rdclr_tmr2(rdclr_tmr2),
    .irq(irq)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    if (a == A_STAT) return {|(m_flag & m_en), m_flag};
    if (a == A_MASK) return {1'b1, m_en};
    return 8'h00;
  endfunction

  // one clock: inputs already driven; model updates at the edge, checks at negedge
  task automatic step(input string req);
    logic [6:0] nf, ne;
    @(posedge clk);
    m_irq = |(m_flag & m_en);
    nf = m_flag;
    ne = m_en;
    if (reg_wr && reg_addr == A_STAT) nf = nf & ~reg_wdata[6:0];
    if (reg_wr && reg_addr == A_MASK) begin
      if (reg_wdata[7]) ne = ne | reg_wdata[6:0];
      else              ne = ne & ~reg_wdata[6:0];
    end
    if (rdclr_shift) nf[2] = 1'b0;
    if (rdclr_tmr2)  nf[5] = 1'b0;
    if (rdclr_tmr1)  nf[6] = 1'b0;
    nf = nf | set_evt;
    m_flag = nf;
    m_en = ne;
    @(negedge clk);
    check({req, "/R1 irq"}, {7'd0, irq}, {7'd0, m_irq});
    check(req, reg_rdata, exp_rd(reg_addr));
  endtask

  task automatic idle();
    reg_wr = 0; reg_wdata = 0; set_evt = 0;
    rdclr_shift = 0; rdclr_tmr1 = 0; rdclr_tmr2 = 0;
  endtask

  task automatic cyc(input string req, input logic [3:0] a, input logic w,
                     input logic [7:0] d, input logic [6:0] s,
                     input logic csr, input logic ct1, input logic ct2);
    reg_addr = a; reg_wr = w; reg_wdata = d; set_evt = s;
    rdclr_shift = csr; rdclr_tmr1 = ct1; rdclr_tmr2 = ct2;
    step(req);
    idle();
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    reg_addr = A_STAT;
    rst_n = 0;
    m_flag = 0; m_en = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 status", reg_rdata, 8'h00);
    check("R10 irq", {7'd0, irq}, 8'h00);
    rst_n = 1;
    reg_addr = A_MASK;
    #1;
    check("R10 mask", reg_rdata, 8'h80);

    // R8 each bit including unassigned ones
    for (int i = 0; i < 7; i++) cyc("R8 set", A_STAT, 0, 0, 7'(1 << i), 0, 0, 0);
    cyc("R5 status no enables", A_STAT, 0, 0, 0, 0, 0, 0);
    // R2 write-one-to-clear
    cyc("R2 w1c", A_STAT, 1, 8'h44, 0, 0, 0, 0);
    cyc("R2 hold", A_STAT, 1, 8'h00, 0, 0, 0, 0);
    // R3 enable set
    cyc("R3 en set", A_MASK, 1, 8'hA1, 0, 0, 0, 0);
    cyc("R5 summary", A_STAT, 0, 0, 0, 0, 0, 0);
    cyc("R1 irq high", A_STAT, 0, 0, 0, 0, 0, 0);
    // R4 enable clear
    cyc("R4 en clr", A_MASK, 1, 8'h21, 0, 0, 0, 0);
    cyc("R6 mask read", A_MASK, 0, 0, 0, 0, 0, 0);
    cyc("R1 irq low", A_STAT, 0, 0, 0, 0, 0, 0);
    // R7 strobes
    cyc("R7 prep", A_STAT, 0, 0, 7'h7F, 0, 0, 0);
    cyc("R7 shift", A_STAT, 0, 0, 0, 1, 0, 0);
    cyc("R7 tmr2", A_STAT, 0, 0, 0, 0, 0, 1);
    cyc("R7 tmr1", A_STAT, 0, 0, 0, 0, 1, 0);
    // R9 collisions
    cyc("R9 write vs set", A_STAT, 1, 8'h7F, 7'h20, 0, 0, 0);
    cyc("R9 strobe vs set", A_STAT, 0, 0, 7'h40, 0, 1, 0);
    cyc("R9 all strobes vs set", A_STAT, 0, 0, 7'h64, 1, 1, 1);
    // R11 other address
    cyc("R11 write other", 4'h3, 1, 8'hFF, 0, 0, 0, 0);
    cyc("R11 write other 2", 4'h0, 1, 8'h7F, 0, 0, 0, 0);
    cyc("R11 status after", A_STAT, 0, 0, 0, 0, 0, 0);
    cyc("R11 mask after", A_MASK, 0, 0, 0, 0, 0, 0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int sel;
      logic [3:0] a;
      sel = $urandom_range(0, 4);
      a = (sel < 2) ? A_STAT : (sel < 4) ? A_MASK : 4'($urandom_range(0, 12));
      cyc("R8 R9 random", a, 1'($urandom_range(0, 2) == 0), 8'($urandom),
          ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h00,
          1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
          1'($urandom_range(0, 3) == 0));
    end

    // reset mid-run
    reg_addr = A_STAT;
    rst_n = 0;
    m_flag = 0; m_en = 0; m_irq = 0;
    @(negedge clk);
    check("R10 reapplied", reg_rdata, 8'h00);
    check("R10 irq reapplied", {7'd0, irq}, 8'h00);
    rst_n = 1;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule